// File: doc/BRIEF.md
# Memory Page Protection Checker

This block stands in front of a small word-addressed memory and vets every access against a permission attribute held for the page the access falls in. A request carries an address, a read/write flag, a three-bit initiator number and a flag that marks a direct access from the local processor. The memory is split into 16 equal pages, and the page number is taken from the upper address bits. Local-processor accesses are granted by one bit of the page attribute. Accesses from system masters and DMA engines are granted by a separate bit for each initiator number. DMA transfers started by the local processor count as remote accesses.

An access that is refused never reaches the memory. A refused read completes with all-zero data. A refused write is dropped. The first refusal is recorded in a fault status word, and an interrupt line stays high until software clears it. Refusals that arrive while a fault is already held still block their accesses, and they set a sticky overflow bit. Software reaches the attributes, the status word and a write-one-to-clear register through a single-cycle register port.

Top module: `mem_prot_guard`

## Requirements
- R1: Each page owns a 7-bit attribute. Bit i (i = 0..5) allows remote initiator i and bit 6 allows local-processor accesses. Register address p (0..15) reads and writes page p's attribute, zero-extended, and every attribute resets to 0x7F.
- R2: A request with req_local = 1 is granted exactly when bit 6 of its page attribute is 1, whatever req_id holds.
- R3: A request with req_local = 0 is granted exactly when the attribute bit selected by req_id is 1. Initiator numbers 6 and 7 have no bit and are always refused.
- R4: Each request produces rsp_valid one cycle later. rsp_denied is high in that cycle exactly when the request was refused.
- R5: A granted read returns the stored word. A refused read returns zero, and every write response returns zero data.
- R6: A refused write leaves memory unchanged. A granted write stores req_wdata at req_addr.
- R7: On a refusal while no fault is held, the status word at register address 16 captures: bit 0 valid = 1, bit 2 = the write flag, bit 3 = the local flag, bits 6:4 = the initiator number, and bits 23:16 = the address. The status word reads 0 after reset.
- R8: fault_irq equals the status valid bit. Once set, it stays high until software clears it.
- R9: A refusal while valid is held leaves the captured fields unchanged and sets the overflow bit, bit 1 of the status word.
- R10: Writing register address 17 clears valid where wdata bit 0 is 1 and clears overflow where wdata bit 1 is 1. A refusal in the same cycle as a valid-clear is captured as a new fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Write data |
| req_id | input | 3 | Initiator number |
| req_local | input | 1 | Direct access from the local processor |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_denied | output | 1 | Request was refused |
| rsp_rdata | output | 32 | Read data (zero when refused or for writes) |
| cfg_sel | input | 1 | Register port access |
| cfg_write | input | 1 | 1 = register write, 0 = register read |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid the cycle after a read |
| fault_irq | output | 1 | Fault held, toward the interrupt controller |

## Verification
The assertions assume that the request inputs are meaningful only while req_valid is high. They also assume that a register-port write to the clear address is the only way software lowers the interrupt. The bench never holds req_valid for more than one cycle per call, so each request maps to exactly one response. It drives register accesses and requests on the falling edge, and it combines them in one cycle only in the deliberate clear-versus-fault collision. Every other status expectation rests on accesses that are strictly ordered.

// File: rtl/prot_pkg.sv
// Shared constants and types for the page protection checker.
// Assumes six remote initiator numbers and one local-processor grant bit.
package prot_pkg;
    localparam int NUM_RID   = 6;
    localparam int ID_W      = 3;
    localparam int ATTR_W    = NUM_RID + 1;
    localparam int LOCAL_BIT = NUM_RID;
    localparam int REG_W     = 32;

    // Combined setting of the selected remote bit and the local bit.
    typedef enum logic [1:0] {
        PERM_NONE        = 2'b00,
        PERM_LOCAL_ONLY  = 2'b01,
        PERM_REMOTE_ONLY = 2'b10,
        PERM_ALL         = 2'b11
    } perm_mode_e;

    // Captured details of a refused access.
    typedef struct packed {
        logic            is_write;
        logic            is_local;
        logic [ID_W-1:0] id;
    } fault_info_t;
endpackage

// File: rtl/prot_attr_bank.sv
// Page attribute register bank: one register per page, written from the
// register port and read by page number for the access check and for
// the register port. Assumes wr_en is asserted only for page addresses.
module prot_attr_bank
    import prot_pkg::*;
#(
    parameter int PAGES     = 16,
    parameter int PAGE_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PAGE_BITS-1:0] wr_page,
    input  logic [ATTR_W-1:0]    wr_attr,
    input  logic [PAGE_BITS-1:0] chk_page,
    output logic [ATTR_W-1:0]    chk_attr,
    input  logic [PAGE_BITS-1:0] rd_page,
    output logic [ATTR_W-1:0]    rd_attr
);
    localparam logic [ATTR_W-1:0] ATTR_OPEN = '1;

    logic [ATTR_W-1:0] attr_q [PAGES];

    for (genvar g = 0; g < PAGES; g++) begin : g_page
        // Hold one page attribute; open on reset so memory works unconfigured.
        always_ff @(posedge clk) begin
            if (!rst_n)
                attr_q[g] <= ATTR_OPEN;
            else if (wr_en && (wr_page == PAGE_BITS'(g)))
                attr_q[g] <= wr_attr;
        end
    end

    // Select attributes for the access check and the register read path.
    always_comb begin
        chk_attr = attr_q[chk_page];
        rd_attr  = attr_q[rd_page];
    end
endmodule

// File: rtl/prot_decide.sv
// Permission decision: combines the page attribute with the requester's
// initiator number and local flag. Purely combinational.
// Assumes initiator numbers at or above NUM_RID have no allow bit.
module prot_decide
    import prot_pkg::*;
(
    input  logic [ATTR_W-1:0] attr,
    input  logic [ID_W-1:0]   id,
    input  logic              is_local,
    output logic              grant
);
    logic       rid_bit;
    perm_mode_e mode;

    // Pick the remote allow bit; unknown initiators get none.
    always_comb begin
        rid_bit = 1'b0;
        for (int i = 0; i < NUM_RID; i++)
            if (id == ID_W'(i))
                rid_bit = attr[i];
    end

    // Form the permission mode and grant by requester class.
    always_comb begin
        mode = perm_mode_e'({rid_bit, attr[LOCAL_BIT]});
        unique case (mode)
            PERM_NONE:        grant = 1'b0;
            PERM_LOCAL_ONLY:  grant = is_local;
            PERM_REMOTE_ONLY: grant = !is_local;
            PERM_ALL:         grant = 1'b1;
            default:          grant = 1'b0;
        endcase
    end
endmodule

// File: rtl/prot_fault_log.sv
// Fault status recorder: captures the first refused access, keeps a
// sticky overflow for later ones, and drives the interrupt level.
// Assumes fault is a single-cycle pulse per refused request.
module prot_fault_log
    import prot_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  fault_info_t       fault_info,
    input  logic [ADDR_W-1:0] fault_addr,
    input  logic              clr_valid,
    input  logic              clr_ovf,
    output logic [REG_W-1:0]  status,
    output logic              irq
);
    logic              valid_q;
    logic              ovf_q;
    fault_info_t       info_q;
    logic [ADDR_W-1:0] addr_q;
    logic              take;

    // A new fault is recorded when nothing is held or the hold is being cleared.
    always_comb take = fault && (!valid_q || clr_valid);

    // Track the valid flag and the captured details.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            info_q  <= '0;
            addr_q  <= '0;
        end else if (take) begin
            valid_q <= 1'b1;
            info_q  <= fault_info;
            addr_q  <= fault_addr;
        end else if (clr_valid) begin
            valid_q <= 1'b0;
        end
    end

    // Track the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (fault && valid_q && !clr_valid)
            ovf_q <= 1'b1;
        else if (clr_ovf)
            ovf_q <= 1'b0;
    end

    // Pack the status word and drive the interrupt level.
    always_comb begin
        status        = '0;
        status[0]     = valid_q;
        status[1]     = ovf_q;
        status[2]     = info_q.is_write;
        status[3]     = info_q.is_local;
        status[6:4]   = info_q.id;
        status[16 +: ADDR_W] = addr_q;
        irq           = valid_q;
    end
endmodule

// File: rtl/prot_sram.sv
// Word memory behind the checker: synchronous write, registered read.
// Assumes we and re are never high together.
module prot_sram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    // Store granted writes and register granted reads.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        if (re)
            rdata <= mem[addr];
    end
endmodule

// File: rtl/mem_prot_guard.sv
// Page protection checker in front of a word memory. Every request is
// checked against its page attribute; refused accesses are blocked,
// answered with zero data and logged. Register port: pages at 0..PAGES-1,
// status at PAGES, write-one-to-clear at PAGES+1.
// Assumes ADDR_W <= 16 so the address fits the status word.
module mem_prot_guard
    import prot_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 4,
    localparam int PAGES    = 1 << PAGE_BITS,
    localparam int CFG_AW   = $clog2(PAGES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_local,
    output logic              rsp_valid,
    output logic              rsp_denied,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              cfg_sel,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              fault_irq
);
    localparam logic [CFG_AW-1:0] STAT_ADDR = CFG_AW'(PAGES);
    localparam logic [CFG_AW-1:0] CLR_ADDR  = CFG_AW'(PAGES + 1);

    logic [PAGE_BITS-1:0] req_page;
    logic [ATTR_W-1:0]    chk_attr;
    logic [ATTR_W-1:0]    rd_attr;
    logic                 grant;
    logic                 attr_we;
    logic                 clr_hit;
    logic                 mem_we;
    logic                 mem_re;
    logic                 fault;
    logic                 rd_ok_q;
    logic [DATA_W-1:0]    mem_q;
    logic [REG_W-1:0]     status;
    fault_info_t          finfo;

    // Decode page number, register writes and request outcome.
    always_comb begin
        req_page = req_addr[ADDR_W-1 -: PAGE_BITS];
        attr_we  = cfg_sel && cfg_write && (cfg_addr < STAT_ADDR);
        clr_hit  = cfg_sel && cfg_write && (cfg_addr == CLR_ADDR);
        mem_we   = req_valid && req_write && grant;
        mem_re   = req_valid && !req_write && grant;
        fault    = req_valid && !grant;
        finfo    = '{is_write: req_write, is_local: req_local, id: req_id};
    end

    prot_attr_bank #(
        .PAGES     (PAGES),
        .PAGE_BITS (PAGE_BITS)
    ) u_attr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (attr_we),
        .wr_page  (cfg_addr[PAGE_BITS-1:0]),
        .wr_attr  (cfg_wdata[ATTR_W-1:0]),
        .chk_page (req_page),
        .chk_attr (chk_attr),
        .rd_page  (cfg_addr[PAGE_BITS-1:0]),
        .rd_attr  (rd_attr)
    );

    prot_decide u_decide (
        .attr     (chk_attr),
        .id       (req_id),
        .is_local (req_local),
        .grant    (grant)
    );

    prot_fault_log #(
        .ADDR_W (ADDR_W)
    ) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault      (fault),
        .fault_info (finfo),
        .fault_addr (req_addr),
        .clr_valid  (clr_hit && cfg_wdata[0]),
        .clr_ovf    (clr_hit && cfg_wdata[1]),
        .status     (status),
        .irq        (fault_irq)
    );

    prot_sram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (req_addr),
        .wdata (req_wdata),
        .rdata (mem_q)
    );

    // Register the response handshake one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_denied <= 1'b0;
            rd_ok_q    <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_denied <= fault;
            rd_ok_q    <= mem_re;
        end
    end

    // Only granted reads expose memory data.
    always_comb rsp_rdata = rd_ok_q ? mem_q : '0;

    // Register port read path.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_rdata <= '0;
        else if (cfg_sel && !cfg_write) begin
            if (cfg_addr < STAT_ADDR)
                cfg_rdata <= REG_W'(rd_attr);
            else if (cfg_addr == STAT_ADDR)
                cfg_rdata <= status;
            else
                cfg_rdata <= '0;
        end
    end
endmodule

// File: rtl/prot_guard_chk.sv
// Temporal checks on the page protection checker's ports.
module prot_guard_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 4,
    localparam int CFG_AW   = $clog2((1 << PAGE_BITS) + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic              rsp_denied,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              cfg_sel,
    input logic              cfg_write,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic              fault_irq
);
    localparam logic [CFG_AW-1:0] CLR_ADDR = CFG_AW'((1 << PAGE_BITS) + 1);

    // R4
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R4
    no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4
    denied_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_denied |-> rsp_valid);

    // R5
    denied_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_denied |-> (rsp_rdata == '0));

    // R8
    denial_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_denied |-> fault_irq);

    // R8
    irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_irq && !(cfg_sel && cfg_write && cfg_addr == CLR_ADDR && cfg_wdata[0]))
        |=> fault_irq);

    // R8
    irq_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_irq && !req_valid) |=> !fault_irq);
endmodule

bind mem_prot_guard prot_guard_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BITS (PAGE_BITS)
) u_guard_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_denied (rsp_denied),
    .rsp_rdata  (rsp_rdata),
    .cfg_sel    (cfg_sel),
    .cfg_write  (cfg_write),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .fault_irq  (fault_irq)
);

// File: tb/mem_prot_guard_test.sv
module mem_prot_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_local = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [2:0]  req_id = '0;
    logic        rsp_valid, rsp_denied, fault_irq;
    logic [31:0] rsp_rdata, cfg_rdata;
    logic        cfg_sel = 1'b0, cfg_write = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;

    int checks = 0;
    int errors = 0;
    logic        got_den;
    logic [31:0] got_data;

    always #2 clk = ~clk;

    mem_prot_guard uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_id(req_id), .req_local(req_local),
        .rsp_valid(rsp_valid), .rsp_denied(rsp_denied), .rsp_rdata(rsp_rdata),
        .cfg_sel(cfg_sel), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fault_irq(fault_irq)
    );

    function automatic logic [31:0] pattern(input logic [7:0] a);
        return {a, ~a, a ^ 8'h3C, 8'h5A};
    endfunction

    function automatic logic allowed(input logic [6:0] attr, input logic [2:0] id,
                                     input logic loc);
        if (loc) return attr[6];
        if (id > 3'd5) return 1'b0;
        return attr[id];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Issue one request at a falling edge; capture the response one cycle later.
    task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                          input logic [2:0] id, input logic loc);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        req_id = id; req_local = loc;
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (rsp_valid !== 1'b1) begin
            errors++;
            $display("FAIL R4: rsp_valid actual %b expected 1", rsp_valid);
        end
        got_den = rsp_denied;
        got_data = rsp_rdata;
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        cfg_sel = 1'b1; cfg_write = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_sel = 1'b0; cfg_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
        cfg_sel = 1'b1; cfg_write = 1'b0; cfg_addr = a;
        @(negedge clk);
        cfg_sel = 1'b0;
        d = cfg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        check("R4 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        check("R8 irq after reset", {31'b0, fault_irq}, 32'h0);
        for (int p = 0; p < 16; p++) begin
            reg_rd(5'(p), r);
            check("R1 attribute reset", r, 32'h7F);
        end
        reg_rd(5'd16, r);
        check("R7 status reset", r, 32'h0);

        // Preload memory through local writes under open attributes (R6)
        for (int a = 0; a < 256; a++) begin
            access(1'b1, 8'(a), pattern(8'(a)), 3'd0, 1'b1);
            check("R6 open write granted", {31'b0, got_den}, 32'h0);
            check("R5 write returns zero", got_data, 32'h0);
        end

        // Sweep all attribute values against every initiator and local flag (R2, R3, R5)
        for (int v = 0; v < 128; v++) begin
            reg_wr(5'(v % 16), 32'(v));
            for (int id = 0; id < 8; id++) begin
                for (int loc = 0; loc < 2; loc++) begin
                    logic [7:0] a;
                    a = 8'(((v % 16) << 4) | (id * 2 + loc));
                    access(1'b0, a, 32'h0, 3'(id), 1'(loc));
                    ok = allowed(7'(v), 3'(id), 1'(loc));
                    if (loc == 1)
                        check("R2 local grant", {31'b0, got_den}, {31'b0, !ok});
                    else
                        check("R3 remote grant", {31'b0, got_den}, {31'b0, !ok});
                    check("R5 read data", got_data, ok ? pattern(a) : 32'h0);
                end
            end
        end
        for (int p = 0; p < 16; p++) reg_wr(5'(p), 32'h7F);
        for (int p = 0; p < 16; p++) begin
            reg_rd(5'(p), r);
            check("R1 attribute readback", r, 32'h7F);
        end
        reg_wr(5'd17, 32'h3);
        check("R10 irq cleared", {31'b0, fault_irq}, 32'h0);
        reg_rd(5'd16, r);
        check("R10 status cleared", r, 32'h0);

        // First fault capture (R7, R8)
        reg_wr(5'd5, 32'h00);
        access(1'b1, 8'h53, 32'hDEADBEEF, 3'd4, 1'b0);
        check("R4 denied flag", {31'b0, got_den}, 32'h1);
        check("R5 denied write data", got_data, 32'h0);
        check("R8 irq raised", {31'b0, fault_irq}, 32'h1);
        reg_rd(5'd16, r);
        check("R7 status capture", r, 32'h0053_0045);

        // Further refusals: overflow, capture kept (R9), memory untouched (R6)
        for (int id = 0; id < 8; id++)
            for (int loc = 0; loc < 2; loc++) begin
                access(1'b1, 8'(8'h50 + id * 2 + loc), 32'hFFFF_0000, 3'(id), 1'(loc));
                check("R6 write refused", {31'b0, got_den}, 32'h1);
            end
        reg_rd(5'd16, r);
        check("R9 overflow set, capture kept", r, 32'h0053_0047);
        repeat (5) @(negedge clk);
        check("R8 irq held", {31'b0, fault_irq}, 32'h1);

        // Clear overflow only (R10)
        reg_wr(5'd17, 32'h2);
        reg_rd(5'd16, r);
        check("R10 overflow clear only", r, 32'h0053_0045);

        // Valid-clear colliding with a new refusal (R10)
        cfg_sel = 1'b1; cfg_write = 1'b1; cfg_addr = 5'd17; cfg_wdata = 32'h1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h57; req_id = 3'd2; req_local = 1'b0;
        @(negedge clk);
        cfg_sel = 1'b0; cfg_write = 1'b0; req_valid = 1'b0;
        reg_rd(5'd16, r);
        check("R10 collision captures new fault", r, 32'h0057_0021);
        reg_wr(5'd17, 32'h1);
        check("R8 irq lowered by clear", {31'b0, fault_irq}, 32'h0);

        // Memory behind refused writes is unchanged (R6)
        reg_wr(5'd5, 32'h7F);
        for (int o = 0; o < 16; o++) begin
            access(1'b0, 8'(8'h50 + o), 32'h0, 3'd0, 1'b1);
            check("R6 refused write left memory", got_data, pattern(8'(8'h50 + o)));
        end

        // Granted remote write and refused local write on a remote-only page (R3, R6)
        reg_wr(5'd6, 32'h04);
        access(1'b1, 8'h61, 32'h1234_5678, 3'd2, 1'b0);
        check("R3 remote id2 write granted", {31'b0, got_den}, 32'h0);
        check("R5 granted write data zero", got_data, 32'h0);
        access(1'b1, 8'h62, 32'h1234_5678, 3'd2, 1'b1);
        check("R2 local write refused", {31'b0, got_den}, 32'h1);
        access(1'b0, 8'h61, 32'h0, 3'd2, 1'b0);
        check("R6 granted write stored", got_data, 32'h1234_5678);
        access(1'b0, 8'h62, 32'h0, 3'd2, 1'b0);
        check("R6 refused write kept old", got_data, pattern(8'h62));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule